// File: doc/BRIEF.md
# Flash Self-Programming Command Engine

This block runs program and check commands against a small on-chip flash array that is held in registers. The array has four blocks of sixteen bytes. Software loads an address register, a data register and a command register through a narrow register bus, then pulses `start`. The engine walks the bytes the command touches, one per cycle, and holds `busy` high while it does so. It pulses `done` for one cycle when it finishes and leaves any error in a status register.

The engine models flash programming rules. Erasing a block sets every byte in it to FFh. Programming a byte can only turn 1 bits into 0 bits. Each byte also has a record of the value that software last asked to store there. The two verify commands compare the array against that record, so a program request that could not be honoured is caught later as a verify mismatch.

Top module: `flash_cmd_engine`

## Requirements
- R1: Register offset 0 holds the command. Only bits [2:0] are stored, bits [7:3] always read as 0, and the register reads 00h after reset.
- R2: Command codes in bits [2:0]: 1 checks a whole block against the recorded values, 2 checks one addressed byte against its recorded value, 3 erases a block, 4 checks a block for blankness, and 5 programs one byte.
- R3: A start with code 0, 6 or 7 never raises `busy`. It pulses `done` in the next cycle and sets the program error flag (status bit 2).
- R4: Erase sets every byte of the block chosen by address bits [5:4] to FFh, and also sets the recorded values of those bytes to FFh. `busy` stays high for 16 cycles.
- R5: Program stores the bitwise AND of the old byte and the data register at the byte chosen by address bits [5:0], and records the data register value as that byte's recorded value. `busy` stays high for 1 cycle.
- R6: When a program request asks for a 1 in a bit that currently holds 0, status bit 2 is set.
- R7: Blank check sets status bit 1 when any byte of the chosen block is not FFh, and leaves it clear otherwise.
- R8: Both verify commands set status bit 1 when a byte they cover differs from its recorded value, and leave it clear otherwise.
- R9: `done` is a single-cycle pulse that is never high together with `busy`. It arrives in the cycle after the last busy cycle.
- R10: While `busy` is high, `start` and writes to the command, address and data registers have no effect.
- R11: Status bits 1 and 2 at offset 3 stay set until software writes 1 to the same bit. A new command does not clear them.
- R12: Register offsets are 0 command, 1 address, 2 data and 3 status. After reset, every array byte and every recorded value is FFh and all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write enable |
| regAddr | input | 2 | Register offset for both read and write |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for `regAddr`, combinational |
| start | input | 1 | Starts the command held in the command register |
| busy | output | 1 | High while the engine is processing bytes |
| done | output | 1 | One-cycle pulse when a command ends |

## Verification
The hardest case to reach is a verify failure, because the array can only be seen through commands. To get there, the stimulus first programs a byte, then programs the same byte again with data that needs an erased bit. The second request leaves the array holding the AND of the two values while the recorded value holds the second value. Verify byte and verify block then have to report the mismatch, and an erase followed by a verify has to clear it. The case where a command is ignored while the engine is busy is reached by injecting `start` and register writes in the middle of a block erase. The engine still runs for exactly 16 busy cycles, the register readbacks stay unchanged, and only one `done` pulse appears.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [2:0] OP_VFY_BLOCK = 3'd1;
  localparam logic [2:0] OP_VFY_BYTE  = 3'd2;
  localparam logic [2:0] OP_ERASE     = 3'd3;
  localparam logic [2:0] OP_BLANK     = 3'd4;
  localparam logic [2:0] OP_WRITE     = 3'd5;

  localparam logic [1:0] RA_CMD  = 2'd0;
  localparam logic [1:0] RA_ADDR = 2'd1;
  localparam logic [1:0] RA_DATA = 2'd2;
  localparam logic [1:0] RA_STAT = 2'd3;

  localparam int ST_VERR_BIT = 1;
  localparam int ST_WERR_BIT = 2;

  localparam logic [7:0] ERASED = 8'hFF;

  // Strobes from control to datapath
  typedef struct packed {
    logic       act;     // process one byte this cycle
    logic       single;  // command covers only the addressed byte
    logic [2:0] op;      // operation being run
    logic       abort;   // prohibited code launched this cycle
  } fstrobe_t;

  function automatic logic opLegal(input logic [2:0] c);
    return (c >= OP_VFY_BLOCK) && (c <= OP_WRITE);
  endfunction

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter  int BLOCK_BYTES = 16,
  localparam int OFFW        = $clog2(BLOCK_BYTES)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [2:0]      cmdCode,
  output logic            busy,
  output logic            done,
  output fstrobe_t        stb,
  output logic [OFFW-1:0] offset
);

  localparam logic [OFFW-1:0] LAST_OFF = OFFW'(BLOCK_BYTES - 1);

  logic            runQ;
  logic            doneQ;
  logic [2:0]      opQ;
  logic [OFFW-1:0] cntQ;
  logic            singleOp;
  logic            launch;
  logic            abortNow;
  logic            finish;

  assign singleOp = (opQ == OP_WRITE) || (opQ == OP_VFY_BYTE);
  assign launch   = start && !runQ && opLegal(cmdCode);
  assign abortNow = start && !runQ && !opLegal(cmdCode);
  assign finish   = runQ && (singleOp || (cntQ == LAST_OFF));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      doneQ <= 1'b0;
      opQ   <= '0;
      cntQ  <= '0;
    end else begin
      doneQ <= finish || abortNow;
      if (launch) begin
        runQ <= 1'b1;
        opQ  <= cmdCode;
        cntQ <= '0;
      end else if (runQ) begin
        cntQ <= cntQ + 1'b1;
        if (finish) runQ <= 1'b0;
      end
    end
  end

  always_comb begin
    stb.act    = runQ;
    stb.single = singleOp;
    stb.op     = opQ;
    stb.abort  = abortNow;
  end

  assign busy   = runQ;
  assign done   = doneQ;
  assign offset = cntQ;

endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter  int BLOCKS      = 4,
  parameter  int BLOCK_BYTES = 16,
  localparam int DEPTH       = BLOCKS * BLOCK_BYTES,
  localparam int ADDRW       = $clog2(DEPTH),
  localparam int OFFW        = $clog2(BLOCK_BYTES)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWe,
  input  logic [1:0]      regAddr,
  input  logic [7:0]      regWdata,
  output logic [7:0]      regRdata,
  input  logic            busy,
  input  fstrobe_t        stb,
  input  logic [OFFW-1:0] offset,
  output logic [2:0]      cmdCode
);

  localparam logic [ADDRW-1:0] OFF_MASK = ADDRW'(BLOCK_BYTES - 1);

  logic [2:0]       cmdQ;
  logic [ADDRW-1:0] addrQ;
  logic [7:0]       dataQ;
  logic             vErrQ;
  logic             wErrQ;
  logic [7:0]       cellQ [DEPTH];
  logic [7:0]       refQ  [DEPTH];

  logic [ADDRW-1:0] effIdx;
  logic [7:0]       curByte;
  logic [7:0]       refByte;
  logic             cfgWe;
  logic             setV, setW, clrV, clrW;
  logic             isVerify;

  assign cfgWe   = regWe && !busy;
  assign effIdx  = stb.single ? addrQ : ((addrQ & ~OFF_MASK) | ADDRW'(offset));
  assign curByte = cellQ[effIdx];
  assign refByte = refQ[effIdx];

  assign isVerify = (stb.op == OP_VFY_BLOCK) || (stb.op == OP_VFY_BYTE);
  assign setV = stb.act && (((stb.op == OP_BLANK) && (curByte != ERASED)) ||
                            (isVerify && (curByte != refByte)));
  assign setW = stb.abort || (stb.act && (stb.op == OP_WRITE) && (|(dataQ & ~curByte)));
  assign clrV = regWe && (regAddr == RA_STAT) && regWdata[ST_VERR_BIT];
  assign clrW = regWe && (regAddr == RA_STAT) && regWdata[ST_WERR_BIT];

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ  <= '0;
      addrQ <= '0;
      dataQ <= '0;
    end else if (cfgWe) begin
      case (regAddr)
        RA_CMD:  cmdQ  <= regWdata[2:0];
        RA_ADDR: addrQ <= regWdata[ADDRW-1:0];
        RA_DATA: dataQ <= regWdata;
        default: ;
      endcase
    end
  end

  // Sticky status, set wins over clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vErrQ <= 1'b0;
      wErrQ <= 1'b0;
    end else begin
      vErrQ <= setV || (vErrQ && !clrV);
      wErrQ <= setW || (wErrQ && !clrW);
    end
  end

  // Array and recorded values, one byte per cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        cellQ[i] <= ERASED;
        refQ[i]  <= ERASED;
      end
    end else if (stb.act) begin
      case (stb.op)
        OP_ERASE: begin
          cellQ[effIdx] <= ERASED;
          refQ[effIdx]  <= ERASED;
        end
        OP_WRITE: begin
          cellQ[effIdx] <= curByte & dataQ;
          refQ[effIdx]  <= dataQ;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      RA_CMD:  regRdata[2:0] = cmdQ;
      RA_ADDR: regRdata[ADDRW-1:0] = addrQ;
      RA_DATA: regRdata = dataQ;
      default: begin
        regRdata[ST_VERR_BIT] = vErrQ;
        regRdata[ST_WERR_BIT] = wErrQ;
      end
    endcase
  end

  assign cmdCode = cmdQ;

endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_cmd_pkg::*;
#(
  parameter int BLOCKS      = 4,
  parameter int BLOCK_BYTES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       start,
  output logic       busy,
  output logic       done
);

  localparam int OFFW = $clog2(BLOCK_BYTES);

  fstrobe_t        stb;
  logic [OFFW-1:0] offset;
  logic [2:0]      cmdCode;

  flash_cmd_ctrl #(.BLOCK_BYTES(BLOCK_BYTES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .cmdCode (cmdCode),
    .busy    (busy),
    .done    (done),
    .stb     (stb),
    .offset  (offset)
  );

  flash_cmd_dp #(.BLOCKS(BLOCKS), .BLOCK_BYTES(BLOCK_BYTES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .busy     (busy),
    .stb      (stb),
    .offset   (offset),
    .cmdCode  (cmdCode)
  );

endmodule

// File: rtl/flash_cmd_engine_chk.sv
module flash_cmd_engine_chk #(
  parameter int BLOCK_BYTES = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] regAddr,
  input logic [7:0] regRdata,
  input logic       start,
  input logic       busy,
  input logic       done
);

  logic [7:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN) runLen <= '0;
    else if (busy) runLen <= runLen + 1'b1;
    else runLen <= '0;
  end

  // R9
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done || $past(start)));

  // R4 R5
  run_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ((runLen == 8'd1) || (runLen == 8'(BLOCK_BYTES))));

  // R1
  cmd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd0) |-> (regRdata[7:3] == 5'd0));

  // R3
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

endmodule

bind flash_cmd_engine flash_cmd_engine_chk #(.BLOCK_BYTES(BLOCK_BYTES)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regRdata (regRdata),
  .start    (start),
  .busy     (busy),
  .done     (done)
);

// File: tb/test_flash_cmd_engine.sv
`timescale 1ns/1ps
module test_flash_cmd_engine;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic       start = 1'b0;
  logic       busy;
  logic       done;

  int total = 0;
  int fails = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_engine i_flash_cmd_engine (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .start(start),
    .busy(busy), .done(done)
  );

  // {req, cmd, addr, data, expected status, expected busy cycles}
  localparam int NV = 24;
  localparam logic [47:0] VEC [NV] = '{
    {8'd7,  8'd4, 8'h00, 8'h00, 8'h00, 8'd16}, // R7 fresh block is blank
    {8'd5,  8'd5, 8'h05, 8'h3C, 8'h00, 8'd1},  // R5 program
    {8'd8,  8'd2, 8'h05, 8'h00, 8'h00, 8'd1},  // R8 verify byte passes
    {8'd8,  8'd1, 8'h00, 8'h00, 8'h00, 8'd16}, // R8 verify block passes
    {8'd7,  8'd4, 8'h00, 8'h00, 8'h02, 8'd16}, // R7 block now dirty
    {8'd6,  8'd5, 8'h05, 8'h3F, 8'h04, 8'd1},  // R6 raise zero bits
    {8'd8,  8'd2, 8'h05, 8'h00, 8'h02, 8'd1},  // R8 byte mismatch
    {8'd8,  8'd1, 8'h0A, 8'h00, 8'h02, 8'd16}, // R8 block mismatch
    {8'd4,  8'd3, 8'h07, 8'h00, 8'h00, 8'd16}, // R4 erase block 0
    {8'd4,  8'd4, 8'h00, 8'h00, 8'h00, 8'd16}, // R4 blank after erase
    {8'd8,  8'd1, 8'h00, 8'h00, 8'h00, 8'd16}, // R8 verify after erase
    {8'd5,  8'd5, 8'h05, 8'h0F, 8'h00, 8'd1},  // R5
    {8'd5,  8'd5, 8'h05, 8'h03, 8'h00, 8'd1},  // R5 clears more bits
    {8'd8,  8'd2, 8'h05, 8'h00, 8'h00, 8'd1},  // R8 AND result matches
    {8'd3,  8'd0, 8'h00, 8'h00, 8'h04, 8'd0},  // R3 code 0
    {8'd3,  8'd6, 8'h00, 8'h00, 8'h04, 8'd0},  // R3 code 6
    {8'd3,  8'd7, 8'h00, 8'h00, 8'h04, 8'd0},  // R3 code 7
    {8'd12, 8'd5, 8'h2A, 8'h00, 8'h00, 8'd1},  // R12 block 2 byte 10
    {8'd12, 8'd4, 8'h10, 8'h00, 8'h00, 8'd16}, // R12 block 1 untouched
    {8'd12, 8'd4, 8'h20, 8'h00, 8'h02, 8'd16}, // R12 block 2 dirty
    {8'd2,  8'd2, 8'h2A, 8'h00, 8'h00, 8'd1},  // R2 verify byte code
    {8'd4,  8'd3, 8'h25, 8'h00, 8'h00, 8'd16}, // R4 erase via mid address
    {8'd4,  8'd4, 8'h20, 8'h00, 8'h00, 8'd16}, // R4
    {8'd8,  8'd2, 8'h2A, 8'h00, 8'h00, 8'd1}   // R8 record reset by erase
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #0.5;
    d = regRdata;
  endtask

  task automatic runCmd(input logic [7:0] cmd, input logic [7:0] addr,
                        input logic [7:0] data, input bit clr,
                        output logic [7:0] stat, output int cyc);
    int guard;
    if (clr) regWrite(2'd3, 8'h06);
    regWrite(2'd1, addr);
    regWrite(2'd2, data);
    regWrite(2'd0, cmd);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; guard = 0;
    while (!done && guard < 100) begin
      if (busy) cyc++;
      @(negedge clk);
      guard++;
    end
    if (guard >= 100) chk("R9 done timeout", 0, 1);
    regRead(2'd3, stat);
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    #800000;
    chk("watchdog", 0, 1);
    finishRun();
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] st;
    int cyc;
    int doneCnt;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R12 reset state
    chk("R9 busy reset", int'(busy), 0);
    chk("R9 done reset", int'(done), 0);
    regRead(2'd0, rd); chk("R1 cmd reset", rd, 8'h00);
    regRead(2'd1, rd); chk("R12 addr reset", rd, 8'h00);
    regRead(2'd2, rd); chk("R12 data reset", rd, 8'h00);
    regRead(2'd3, rd); chk("R11 status reset", rd, 8'h00);

    // R1 upper bits dropped
    regWrite(2'd0, 8'hFD);
    regRead(2'd0, rd); chk("R1 cmd readback", rd, 8'h05);
    regWrite(2'd2, 8'hA5);
    regRead(2'd2, rd); chk("R12 data readback", rd, 8'hA5);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      runCmd(VEC[i][39:32], VEC[i][31:24], VEC[i][23:16], 1'b1, st, cyc);
      total++;
      if (st != VEC[i][15:8]) begin
        fails++;
        $display("FAIL R%0d vec %0d status actual=0x%0h expected=0x%0h",
                 VEC[i][47:40], i, st, VEC[i][15:8]);
      end
      total++;
      if (cyc != int'(VEC[i][7:0])) begin
        fails++;
        $display("FAIL R%0d vec %0d busy cycles actual=%0d expected=%0d",
                 VEC[i][47:40], i, cyc, VEC[i][7:0]);
      end
    end

    // R3 illegal: done the cycle after start, busy never rises
    regWrite(2'd0, 8'h06);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R3 busy stays low", int'(busy), 0);
    chk("R3 done next cycle", int'(done), 1);
    @(negedge clk);
    chk("R9 done single pulse", int'(done), 0);

    // R11 sticky and write-one-to-clear
    regWrite(2'd3, 8'h02);
    regRead(2'd3, rd); chk("R11 write 1 to other bit keeps", rd, 8'h04);
    runCmd(8'd3, 8'h30, 8'h00, 1'b0, st, cyc);
    chk("R11 sticky across command", st, 8'h04);
    regWrite(2'd3, 8'h04);
    regRead(2'd3, rd); chk("R11 cleared", rd, 8'h00);

    // R10 start and config writes ignored while busy
    regWrite(2'd3, 8'h06);
    regWrite(2'd1, 8'h30);
    regWrite(2'd0, 8'h03);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; doneCnt = 0;
    for (int k = 0; k < 24; k++) begin
      if (busy) cyc++;
      if (done) doneCnt++;
      regWe = 1'b0; start = 1'b0;
      if (k == 3) begin regWe = 1'b1; regAddr = 2'd0; regWdata = 8'h04; start = 1'b1; end
      if (k == 5) begin regWe = 1'b1; regAddr = 2'd1; regWdata = 8'h00; start = 1'b1; end
      if (k == 7) begin regWe = 1'b1; regAddr = 2'd2; regWdata = 8'h77; end
      @(negedge clk);
    end
    regWe = 1'b0; start = 1'b0;
    chk("R10 busy length unchanged", cyc, 16);
    chk("R9 one done pulse", doneCnt, 1);
    regRead(2'd0, rd); chk("R10 cmd write ignored", rd, 8'h03);
    regRead(2'd1, rd); chk("R10 addr write ignored", rd, 8'h30);
    regRead(2'd2, rd); chk("R10 data write ignored", rd, 8'h00);
    regRead(2'd3, rd); chk("R10 no extra status", rd, 8'h00);

    // R5 program in block 3 then verify block catches nothing
    runCmd(8'd5, 8'h3F, 8'h81, 1'b1, st, cyc);
    chk("R5 program last byte", st, 8'h00);
    runCmd(8'd1, 8'h30, 8'h00, 1'b1, st, cyc);
    chk("R8 block 3 verify", st, 8'h00);
    runCmd(8'd4, 8'h31, 8'h00, 1'b1, st, cyc);
    chk("R7 block 3 not blank", st, 8'h02);

    finishRun();
  end

endmodule